// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is the slave end of a serial memory. A bus master selects it with an active-low select line, clocks a one-byte command in on the serial data input, and depending on the command sends three address bytes and then streams bytes in or out. The byte array sits inside the block and accepts each incoming byte the moment its last bit arrives. No write interval exists and no ready flag needs polling: once select is released, the next transaction can start at once.

The select, clock and data pins are brought into the system clock domain through short synchronizer chains. The block accepts clock idle-low (mode 0) and clock idle-high (mode 3) framing. It learns which one is in use from the clock level it sees when select falls. A write-enable latch guards the array. A status command reads that latch back. The array size is a parameter. The full-size part uses an 18-bit byte address, which gives 262,144 bytes. The default parameter value is kept small so that elaboration stays light.

Top module: `spiMemSlave`

## Requirements
- R1: While select is high, the output-enable pin is low and the data-out pin is low; both stay so after reset.
- R2: The first byte after select falls is the command: 0x03 reads, 0x02 writes, 0x06 sets the write-enable latch, 0x04 clears it, 0x05 returns the status byte. 0x06 and 0x04 need no further bytes.
- R3: A read or write command is followed by three address bytes, most significant first; only the low ADDR_W bits of the 24 received bits select a location, and the rest are discarded.
- R4: Mode 0 and mode 3 both work, and the mode is captured from the clock level at each select fall; in mode 3 the leading falling clock edge moves no data.
- R5: Bits travel most significant first; input is sampled on rising clock edges and output changes only after falling edges.
- R6: A write byte is stored when its eighth bit is received, and a read in the very next transaction returns it.
- R7: Data bytes of a write are discarded unless the write-enable latch is set; the latch is cleared when a write transaction's select rises.
- R8: The status byte carries the write-enable latch in bit 1 with all other bits zero, and it repeats for as long as the master keeps clocking.
- R9: The address advances by one after each data byte and wraps from the top location to zero, for both reads and writes.
- R10: Only one command is taken per select assertion; later bytes that do not belong to it are ignored until select rises.
- R11: An unknown command byte has no effect on the array or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for the data-out pin; low means high impedance |

## Verification
Every pin passes through two synchronizer flops and an edge register, so a serial clock edge takes effect three system clocks after the bench drives it. Output data reaches the pin about three system clocks after a falling edge. The bench holds each serial clock phase for eight system clocks and samples the data-out pin just before it raises the clock, well past that latency. A stored byte is committed before select can rise, so the bench starts the read-back transaction as soon as select has been high for a few cycles. Status and array results are compared byte by byte against a bench model of the array and the latch.

// File: rtl/spiMemPkg.sv
package spiMemPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_STATUS,
    ST_SKIP
  } spiState_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;    // rising edge: shift one input bit
    logic rxBit;      // synchronized input data bit
    logic addrShift;  // full address byte received
    logic memWrite;   // commit received byte to array
    logic loadRead;   // load array byte into output register
    logic loadStatus; // load status byte into output register
    logic txShift;    // falling edge inside a byte: next output bit
    logic txClear;    // select fell: empty output register
  } dpStrobe_t;

endpackage

// File: rtl/spiMemCtrl.sv
module spiMemCtrl
  import spiMemPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] rxByte,
  output dpStrobe_t  strb,
  output logic [7:0] statusByte,
  output logic       csActive
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] csPipe, clkPipe, dinPipe;
  logic csNow, sclkNow, dinNow;
  logic csPrev, sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      dinPipe <= '0;
      csPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[TOP-1:0], csN};
      clkPipe <= {clkPipe[TOP-1:0], sclk};
      dinPipe <= {dinPipe[TOP-1:0], mosi};
      csPrev  <= csNow;
      sclkPrev <= sclkNow;
    end
  end

  assign csNow   = csPipe[TOP];
  assign sclkNow = clkPipe[TOP];
  assign dinNow  = dinPipe[TOP];

  logic csStart, csEnd, rise, fall, fallOk, byteDone;
  spiState_t state;
  logic [2:0] bitCnt;
  logic [1:0] addrCnt;
  logic mode3, riseSeen, wel, writeCmd;

  assign csStart  = csPrev & ~csNow;
  assign csEnd    = ~csPrev & csNow;
  assign rise     = ~csNow & ~sclkPrev & sclkNow;
  assign fall     = ~csNow & sclkPrev & ~sclkNow;
  // mode 3 starts with the clock high: its first falling edge is not data
  assign fallOk   = fall & (~mode3 | riseSeen);
  assign byteDone = rise & (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      addrCnt  <= '0;
      mode3    <= 1'b0;
      riseSeen <= 1'b0;
      wel      <= 1'b0;
      writeCmd <= 1'b0;
    end else if (csStart) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      addrCnt  <= '0;
      mode3    <= sclkNow;
      riseSeen <= 1'b0;
      writeCmd <= 1'b0;
    end else if (csEnd) begin
      state <= ST_IDLE;
      if (writeCmd) wel <= 1'b0;
    end else begin
      if (rise) begin
        bitCnt   <= bitCnt + 3'd1;
        riseSeen <= 1'b1;
      end
      if (byteDone) begin
        unique case (state)
          ST_CMD: begin
            unique case (rxByte)
              OP_READ:  state <= ST_ADDR;
              OP_WRITE: begin
                state    <= ST_ADDR;
                writeCmd <= 1'b1;
              end
              OP_WREN: begin
                wel   <= 1'b1;
                state <= ST_SKIP;
              end
              OP_WRDI: begin
                wel   <= 1'b0;
                state <= ST_SKIP;
              end
              OP_RDSR:  state <= ST_STATUS;
              default:  state <= ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            addrCnt <= addrCnt + 2'd1;
            if (addrCnt == 2'd2) state <= writeCmd ? ST_WDATA : ST_RDATA;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.rxShift    = rise;
    strb.rxBit      = dinNow;
    strb.addrShift  = byteDone & (state == ST_ADDR);
    strb.memWrite   = byteDone & (state == ST_WDATA) & wel;
    strb.loadRead   = fallOk & (bitCnt == 3'd0) & (state == ST_RDATA);
    strb.loadStatus = fallOk & (bitCnt == 3'd0) & (state == ST_STATUS);
    strb.txShift    = fallOk & (bitCnt != 3'd0);
    strb.txClear    = csStart;
  end

  assign statusByte = {6'b0, wel, 1'b0};
  assign csActive   = ~csNow;

  // R7: the array is only written while the latch is set
  a_r7_wel_gate: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWrite |-> wel);

  // R10: once past the command byte, the command state is not re-entered in the same select
  a_r10_single_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_CMD && state != ST_IDLE && !csStart) |=> state != ST_CMD);

  // R4: captured mode holds for the whole select assertion
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!csNow && !csStart) |=> $stable(mode3));

endmodule

// File: rtl/spiMemDatapath.sv
module spiMemDatapath
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic [7:0] statusByte,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [6:0] rxReg;
  logic [7:0] txReg;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W+7:0] addrNext;

  assign rxByte   = {rxReg, strb.rxBit};
  assign addrNext = {addr, rxByte};

  always_ff @(posedge clk) begin
    if (strb.memWrite) mem[addr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      addr  <= '0;
    end else begin
      if (strb.rxShift) rxReg <= rxByte[6:0];
      if (strb.addrShift) addr <= addrNext[ADDR_W-1:0];
      else if (strb.memWrite || strb.loadRead) addr <= addr + 1'b1;
      if (strb.txClear) txReg <= '0;
      else if (strb.loadRead) txReg <= mem[addr];
      else if (strb.loadStatus) txReg <= statusByte;
      else if (strb.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign txBit = txReg[7];

  // R9: every data byte moves the pointer by exactly one, wrapping at the top
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWrite || strb.loadRead) |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R5: the output moves one bit toward the pin on each in-byte falling edge
  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txShift && !strb.txClear && !strb.loadRead && !strb.loadStatus)
      |=> txReg[7] == $past(txReg[6]));

endmodule

// File: rtl/spiMemSlave.sv
module spiMemSlave
  import spiMemPkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic misoOe
);

  dpStrobe_t  strb;
  logic [7:0] statusByte;
  logic [7:0] rxByte;
  logic       csActive;
  logic       txBit;

  spiMemCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .rxByte(rxByte), .strb(strb), .statusByte(statusByte), .csActive(csActive)
  );

  spiMemDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .statusByte(statusByte),
    .rxByte(rxByte), .txBit(txBit)
  );

  assign misoOe = csActive;
  assign miso   = csActive & txBit;

  // R1: nothing is driven while deselected
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |-> !miso);

endmodule

// File: tb/spiMemSlave_bench.sv
`timescale 1ns/1ps
module spiMemSlave_bench;

  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, misoOe;

  always #2 clk = ~clk;

  spiMemSlave #(.ADDR_W(ADDR_W)) u_spiMemSlave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoOe(misoOe)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] model [DEPTH];
  bit known [DEPTH];
  bit welModel = 1'b0;
  logic [7:0] buf8 [8];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferByte(input logic [7:0] tx, input bit m3, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (m3) sclk = 1'b0;
      mosi = tx[i];
      waitClk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      if (!m3) sclk = 1'b0;
    end
  endtask

  task automatic selBegin(input bit m3);
    sclk = m3;
    waitClk(6);
    csN = 1'b0;
    waitClk(6);
  endtask

  task automatic selEnd();
    waitClk(6);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic cmdOnly(input logic [7:0] op, input bit m3);
    logic [7:0] rx;
    selBegin(m3);
    xferByte(op, m3, rx);
    selEnd();
    if (op == 8'h06) welModel = 1'b1;
    if (op == 8'h04) welModel = 1'b0;
  endtask

  task automatic sendAddr(input logic [23:0] a, input bit m3);
    logic [7:0] rx;
    xferByte(a[23:16], m3, rx);
    xferByte(a[15:8], m3, rx);
    xferByte(a[7:0], m3, rx);
  endtask

  task automatic writeTx(input bit m3, input logic [23:0] a, input int len);
    logic [7:0] rx;
    int p;
    selBegin(m3);
    xferByte(8'h02, m3, rx);
    sendAddr(a, m3);
    p = int'(a) % DEPTH;
    for (int i = 0; i < len; i++) begin
      xferByte(buf8[i], m3, rx);
      if (welModel) begin
        model[p] = buf8[i];
        known[p] = 1'b1;
      end
      p = (p + 1) % DEPTH;
    end
    selEnd();
    welModel = 1'b0;
  endtask

  task automatic readTx(input string tag, input bit m3, input logic [23:0] a, input int len);
    logic [7:0] rx;
    int p;
    selBegin(m3);
    check({tag, " R1 oe during select"}, misoOe, 1);
    xferByte(8'h03, m3, rx);
    sendAddr(a, m3);
    p = int'(a) % DEPTH;
    for (int i = 0; i < len; i++) begin
      xferByte(8'h06, m3, rx);  // bytes sent during read data are ignored (R10)
      if (known[p]) check(tag, rx, model[p]);
      p = (p + 1) % DEPTH;
    end
    selEnd();
  endtask

  task automatic statusTx(input string tag, input bit m3, input int n);
    logic [7:0] rx;
    selBegin(m3);
    xferByte(8'h05, m3, rx);
    for (int i = 0; i < n; i++) begin
      xferByte(8'h00, m3, rx);
      check(tag, rx, {6'b0, welModel, 1'b0});
    end
    selEnd();
  endtask

  initial begin
    logic [7:0] rx;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    waitClk(5);
    // R1: reset state
    check("R1 reset oe", misoOe, 0);
    check("R1 reset miso", miso, 0);
    rstN = 1'b1;
    waitClk(5);
    check("R1 idle oe", misoOe, 0);

    // R2 R8: latch set/clear via commands, status in both modes
    statusTx("R8 status after reset", 1'b0, 1);
    cmdOnly(8'h06, 1'b0);
    statusTx("R8 status after set (mode0)", 1'b0, 3);
    cmdOnly(8'h04, 1'b1);
    statusTx("R2 status after clear (mode3)", 1'b1, 2);

    // R6 R5 R4: write in mode 3, read back in mode 0 and mode 3
    cmdOnly(8'h06, 1'b1);
    buf8[0] = 8'hA5; buf8[1] = 8'h3C; buf8[2] = 8'h81; buf8[3] = 8'h7E;
    writeTx(1'b1, 24'h000010, 4);
    readTx("R6 readback mode0", 1'b0, 24'h000010, 4);
    readTx("R4 readback mode3", 1'b1, 24'h000010, 4);
    // R7: latch cleared by end of write
    statusTx("R7 latch cleared after write", 1'b0, 1);
    check("R1 idle oe after tx", misoOe, 0);
    check("R1 idle miso after tx", miso, 0);

    // R7: write without latch discarded
    buf8[0] = 8'h5A;
    writeTx(1'b0, 24'h000010, 1);
    readTx("R7 ignored write", 1'b0, 24'h000010, 1);

    // R9: wrap at the top
    cmdOnly(8'h06, 1'b0);
    buf8[0] = 8'hC3; buf8[1] = 8'h18;
    writeTx(1'b0, 24'(DEPTH - 1), 2);
    readTx("R9 wrap read", 1'b1, 24'(DEPTH - 1), 2);

    // R3: upper address bits ignored
    cmdOnly(8'h06, 1'b1);
    buf8[0] = 8'hE7;
    writeTx(1'b1, 24'hABC005, 1);
    readTx("R3 alias low", 1'b0, 24'h000005, 1);
    readTx("R3 alias high", 1'b0, 24'h123405, 1);

    // R10: extra bytes after a no-data command are ignored
    cmdOnly(8'h06, 1'b0);
    selBegin(1'b0);
    xferByte(8'h06, 1'b0, rx);
    xferByte(8'h04, 1'b0, rx);
    xferByte(8'h02, 1'b0, rx);
    selEnd();
    statusTx("R10 latch still set", 1'b0, 1);

    // R11: unknown command changes nothing
    selBegin(1'b1);
    xferByte(8'hAB, 1'b1, rx);
    xferByte(8'h04, 1'b1, rx);
    xferByte(8'h00, 1'b1, rx);
    xferByte(8'h10, 1'b1, rx);
    xferByte(8'h55, 1'b1, rx);
    selEnd();
    statusTx("R11 latch after unknown", 1'b1, 1);
    readTx("R11 array after unknown", 1'b0, 24'h000010, 4);

    // random transactions: R6 R9 R4
    for (int k = 0; k < 18; k++) begin
      bit wm, rm;
      logic [23:0] a;
      int len;
      wm = 1'($urandom);
      rm = 1'($urandom);
      a = 24'($urandom);
      len = 1 + int'($urandom % 3);
      for (int i = 0; i < len; i++) buf8[i] = 8'($urandom);
      cmdOnly(8'h06, wm);
      writeTx(wm, a, len);
      readTx("R6 random readback", rm, a, len);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule